// File: doc/BRIEF.md
# Flash Program and Erase Command Controller

This block sits between a byte-wide register bus, driven by the CPU or a DMA engine, and an abstract flash-array port. Software selects a page through an address-high register and starts either a page erase or a streamed write through a control register. The controller then runs the operation on the array port with a request/done handshake. While an operation is in progress, it holds a busy flag and stalls the CPU.

During a write, bytes arrive one at a time through a write-data register. Each group of four bytes is packed into one 32-bit flash word, least significant byte first. The controller raises a one-cycle DMA trigger whenever it can take the next byte. The programming address advances by one word after each word completes. If the next byte fails to arrive within a set number of cycles, the write ends by itself. An erase aimed at a page whose lock bit is set is refused, and an abort flag is raised.

The page size is 2 KB or 1 KB, chosen by a parameter. This choice changes which address-high bits select the page and how page numbers map to word addresses.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, the status byte is 0x00, and the stall, trigger and array request outputs are low.
- R2: Writing a control value with bit 0 set while idle starts an erase. From the next cycle the status reads 0x81 (busy in bit 7, erase in bit 0). The array request has write-enable low and word address {addr_hi[7:1], 9'b0} in 2 KB mode. After done, the status returns to 0x00.
- R3: In 1 KB mode the erase word address is {addr_hi[6:0], 8'b0}.
- R4: The CPU stall output is high exactly while busy, and therefore whenever the array request is high.
- R5: The array request, address, write-enable and data stay stable until done is returned. The request drops in the cycle after done.
- R6: An erase of a page whose lock-vector bit is 1 makes no array request and leaves busy low. It sets the abort flag (status bit 5, status 0x20). The next accepted command clears the abort flag.
- R7: Writing a control value with bit 1 set while idle (and bit 0 clear) starts a write, and the status reads 0x82. Every four bytes written to the data register form one word, with the first byte in bits 7:0. The word is programmed at the page base address plus the count of words already written.
- R8: The DMA trigger pulses once when the write starts, once after each of the first three bytes of a word, and once when each word completes. It is never high outside a write.
- R9: In write mode, if no data byte arrives for WR_TIMEOUT cycles, the write bit and busy clear by themselves.
- R10: A control write while busy is ignored. No extra array request follows, and the status is unchanged.
- R11: A data byte written while idle is ignored. It produces no trigger and no array request, and it does not enter the next packed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address-high, 2 write data |
| reg_wdata | input | 8 | Register write value |
| ctl_status | output | 8 | Status: bit 7 busy, bit 5 abort, bit 1 write, bit 0 erase |
| cpu_stall | output | 1 | CPU stall while an operation runs |
| dma_trig | output | 1 | One-cycle request for the next data byte |
| arr_req | output | 1 | Array operation request |
| arr_we | output | 1 | 1 = program word, 0 = erase page |
| arr_addr | output | AW | Array word address |
| arr_wdata | output | 32 | Word to program |
| arr_done | input | 1 | Array completion, one cycle |
| arr_lock | input | 128 | Page lock vector read from the tail of the last page |

## Verification
The erase path is tried with an address-high value whose bit 0 is set. In 2 KB mode this shows that the low bit is dropped, and the 1 KB instance run with a value whose bit 7 is set shows the opposite field choice. A locked page tells refusal apart from a normal erase. Stray control writes during an erase separate accepted commands from ignored ones. A two-word write with distinct byte values, preceded by bytes written while idle, exposes errors in byte order, address increment and packer clearing. The trigger count and the end of the write on timeout confirm the pacing.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_WCOL, ST_WPROG} fc_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_AHI  = 2'd1;
    localparam logic [1:0] SEL_WDAT = 2'd2;

    localparam int BIT_ERASE = 0;
    localparam int BIT_WRITE = 1;

    localparam int PAGE_W = 7;
    localparam int NPAGES = 2 ** PAGE_W;
endpackage

// File: rtl/fc_page_map.sv
module fc_page_map #(
    parameter int AW      = 16,
    parameter bit PAGE_1K = 1'b0
) (
    input  logic [7:0]                  ahi,
    input  logic [fc_pkg::NPAGES-1:0]   lock,
    output logic [AW-1:0]               base,
    output logic                        locked
);
    localparam int SHIFT = PAGE_1K ? 8 : 9;

    logic [fc_pkg::PAGE_W-1:0] page;

    generate
        if (PAGE_1K) begin : g_small
            assign page = ahi[6:0];
        end else begin : g_large
            assign page = ahi[7:1];
        end
    endgenerate

    assign base   = AW'(page) << SHIFT;
    assign locked = lock[page];
endmodule

// File: rtl/fc_byte_pack.sv
module fc_byte_pack #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [7:0]        byte_in,
    output logic              last,
    output logic [WORD_W-1:0] word
);
    localparam int LANES = WORD_W / 8;
    localparam int CW    = $clog2(LANES);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [7:0]    lane_q [LANES];

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (load) cnt_d = (cnt_q == CW'(LANES - 1)) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          lane_q[g] <= '0;
            else if (clr)                        lane_q[g] <= '0;
            else if (load && cnt_q == CW'(g))    lane_q[g] <= byte_in;
        end
        assign word[g*8 +: 8] = lane_q[g];
    end

    assign last = load && (cnt_q == CW'(LANES - 1));
endmodule

// File: rtl/fc_timeout.sv
module fc_timeout #(
    parameter int LIMIT = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || kick) cnt_d = '0;
        else              cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && !kick && (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
    parameter int AW         = 16,
    parameter bit PAGE_1K    = 1'b0,
    parameter int WR_TIMEOUT = 4000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [1:0]                 reg_sel,
    input  logic [7:0]                 reg_wdata,
    output logic [7:0]                 ctl_status,
    output logic                       cpu_stall,
    output logic                       dma_trig,
    output logic                       arr_req,
    output logic                       arr_we,
    output logic [AW-1:0]              arr_addr,
    output logic [31:0]                arr_wdata,
    input  logic                       arr_done,
    input  logic [fc_pkg::NPAGES-1:0]  arr_lock
);
    import fc_pkg::*;

    typedef struct packed {
        fc_state_e   st;
        logic        abort;
        logic        trig;
        logic [7:0]  ahi;
        logic [AW-1:0] eaddr;
        logic [AW-1:0] waddr;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0] page_base;
    logic          page_locked;
    logic          ctl_wr, ahi_wr, dat_wr;
    logic          pk_last, pk_load, pk_clr;
    logic          tmo_exp;

    fc_page_map #(.AW(AW), .PAGE_1K(PAGE_1K)) u_map (
        .ahi    (r_q.ahi),
        .lock   (arr_lock),
        .base   (page_base),
        .locked (page_locked)
    );

    assign ctl_wr  = reg_we && (reg_sel == SEL_CTRL);
    assign ahi_wr  = reg_we && (reg_sel == SEL_AHI);
    assign dat_wr  = reg_we && (reg_sel == SEL_WDAT);
    assign pk_load = dat_wr && (r_q.st == ST_WCOL);
    assign pk_clr  = (r_q.st == ST_IDLE);

    fc_byte_pack #(.WORD_W(32)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pk_clr),
        .load    (pk_load),
        .byte_in (reg_wdata),
        .last    (pk_last),
        .word    (arr_wdata)
    );

    fc_timeout #(.LIMIT(WR_TIMEOUT)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.st == ST_WCOL),
        .kick    (dat_wr),
        .expired (tmo_exp)
    );

    always_comb begin
        r_d      = r_q;
        r_d.trig = 1'b0;
        if (ahi_wr) r_d.ahi = reg_wdata;
        unique case (r_q.st)
            ST_IDLE: begin
                if (ctl_wr) begin
                    r_d.abort = 1'b0;
                    if (reg_wdata[BIT_ERASE]) begin
                        if (page_locked) begin
                            r_d.abort = 1'b1;
                        end else begin
                            r_d.st    = ST_ERASE;
                            r_d.eaddr = page_base;
                        end
                    end else if (reg_wdata[BIT_WRITE]) begin
                        r_d.st    = ST_WCOL;
                        r_d.waddr = page_base;
                        r_d.trig  = 1'b1;
                    end
                end
            end
            ST_ERASE: begin
                if (arr_done) r_d.st = ST_IDLE;
            end
            ST_WCOL: begin
                if (tmo_exp)      r_d.st   = ST_IDLE;
                else if (pk_last) r_d.st   = ST_WPROG;
                else if (pk_load) r_d.trig = 1'b1;
            end
            ST_WPROG: begin
                if (arr_done) begin
                    r_d.st    = ST_WCOL;
                    r_d.waddr = r_q.waddr + AW'(1);
                    r_d.trig  = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, abort: 1'b0, trig: 1'b0, ahi: '0, eaddr: '0, waddr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    logic busy, writing, erasing;
    assign erasing    = (r_q.st == ST_ERASE);
    assign writing    = (r_q.st == ST_WCOL) || (r_q.st == ST_WPROG);
    assign busy       = erasing || writing;
    assign ctl_status = {busy, 1'b0, r_q.abort, 3'b000, writing, erasing};
    assign cpu_stall  = busy;
    assign dma_trig   = r_q.trig;
    assign arr_req    = erasing || (r_q.st == ST_WPROG);
    assign arr_we     = (r_q.st == ST_WPROG);
    assign arr_addr   = arr_we ? r_q.waddr : r_q.eaddr;
endmodule

// File: rtl/fc_ctrl_chk.sv
module fc_ctrl_chk #(
    parameter int AW      = 16,
    parameter bit PAGE_1K = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    ctl_status,
    input logic          cpu_stall,
    input logic          dma_trig,
    input logic          arr_req,
    input logic          arr_we,
    input logic [AW-1:0] arr_addr,
    input logic [31:0]   arr_wdata,
    input logic          arr_done
);
    localparam int SHIFT = PAGE_1K ? 8 : 9;
    localparam logic [AW-1:0] LOW_MASK = AW'((1 << SHIFT) - 1);

    AST_REQ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> cpu_stall && ctl_status[7]);                                   // R4

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && !arr_done |=> arr_req && $stable(arr_addr) && $stable(arr_we)
                                 && $stable(arr_wdata));                            // R5

    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && arr_done |=> !arr_req);                                         // R5

    AST_ERASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && !arr_we |-> (arr_addr & LOW_MASK) == '0);                       // R2

    AST_TRIG_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_trig |-> ctl_status[1]);                                               // R8

    AST_ABORT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_status[5]) |-> !arr_req && !ctl_status[7]);                       // R6
endmodule

bind flash_cmd_ctrl fc_ctrl_chk #(.AW(AW), .PAGE_1K(PAGE_1K)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_status (ctl_status),
    .cpu_stall  (cpu_stall),
    .dma_trig   (dma_trig),
    .arr_req    (arr_req),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr),
    .arr_wdata  (arr_wdata),
    .arr_done   (arr_done)
);

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
    localparam int LAT = 6;
    localparam int TMO = 30;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         reg_we;
    logic [1:0]   reg_sel;
    logic [7:0]   reg_wdata;
    logic [7:0]   ctl_status;
    logic         cpu_stall, dma_trig, arr_req, arr_we, arr_done;
    logic [15:0]  arr_addr;
    logic [31:0]  arr_wdata;
    logic [127:0] arr_lock;

    logic         k_we;
    logic [1:0]   k_sel;
    logic [7:0]   k_wdata, k_status;
    logic         k_stall, k_trig, k_req, k_rwe, k_done;
    logic [15:0]  k_addr;
    logic [31:0]  k_data;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(.AW(16), .PAGE_1K(1'b0), .WR_TIMEOUT(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ctl_status(ctl_status), .cpu_stall(cpu_stall), .dma_trig(dma_trig),
        .arr_req(arr_req), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_done(arr_done), .arr_lock(arr_lock)
    );

    flash_cmd_ctrl #(.AW(16), .PAGE_1K(1'b1), .WR_TIMEOUT(TMO)) uut_k (
        .clk(clk), .rst_n(rst_n), .reg_we(k_we), .reg_sel(k_sel), .reg_wdata(k_wdata),
        .ctl_status(k_status), .cpu_stall(k_stall), .dma_trig(k_trig),
        .arr_req(k_req), .arr_we(k_rwe), .arr_addr(k_addr), .arr_wdata(k_data),
        .arr_done(k_done), .arr_lock(128'd0)
    );

    typedef struct {
        bit          we;
        int unsigned addr;
        int unsigned data;
    } xact_t;

    xact_t exp_q[$];
    int    checks = 0;
    int    fails  = 0;
    int    trig_cnt = 0;
    bit    done_flag = 0;
    bit    k_seen = 0;
    int unsigned k_addr_seen = 0;

    task automatic chk(input bit ok, input string req, input int unsigned act, input int unsigned expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic push(input bit we, input int unsigned addr, input int unsigned data);
        xact_t e;
        e.we = we; e.addr = addr; e.data = data;
        exp_q.push_back(e);
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic k_wr(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        k_we = 1'b1; k_sel = sel; k_wdata = val;
        @(negedge clk);
        k_we = 1'b0;
    endtask

    // monitor and array responder: pops expected transactions
    initial begin
        arr_done = 1'b0;
        forever begin
            @(negedge clk);
            arr_done = 1'b0;
            if (arr_req && rst_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10/R11 unexpected array request", arr_addr, 0);
                end else begin
                    xact_t e;
                    e = exp_q.pop_front();
                    chk(arr_we == e.we, "R2/R7 array operation kind", arr_we, e.we);
                    chk(arr_addr == e.addr[15:0], "R2/R7 array address", arr_addr, e.addr);
                    if (e.we) chk(arr_wdata == e.data, "R7 packed word", arr_wdata, e.data);
                end
                repeat (LAT - 1) @(negedge clk);
                arr_done = 1'b1;
                @(negedge clk);
                arr_done = 1'b0;
            end
        end
    end

    initial begin
        k_done = 1'b0;
        forever begin
            @(negedge clk);
            k_done = 1'b0;
            if (k_req && rst_n) begin
                k_seen = 1; k_addr_seen = k_addr;
                repeat (2) @(negedge clk);
                k_done = 1'b1;
                @(negedge clk);
                k_done = 1'b0;
            end
        end
    end

    always @(posedge clk) if (rst_n && dma_trig) trig_cnt++;

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        int t0;
        int consumed;
        rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
        k_we = 1'b0; k_sel = '0; k_wdata = '0;
        arr_lock = 128'd1 << 5;
        repeat (3) @(negedge clk);
        chk(ctl_status == 8'h00, "R1 reset status", ctl_status, 8'h00);
        chk(!cpu_stall && !dma_trig && !arr_req, "R1 reset outputs",
            {cpu_stall, dma_trig, arr_req}, 0);
        rst_n = 1'b1;

        // R2 erase, 2 KB mode: 0x07 -> page 3 -> word 1536
        reg_wr(2'd1, 8'h07);
        push(1'b0, 1536, 0);
        reg_wr(2'd0, 8'h01);
        chk(ctl_status == 8'h81, "R2 busy erase status", ctl_status, 8'h81);
        chk(cpu_stall == 1'b1, "R4 stall during erase", cpu_stall, 1);
        // R10 commands while busy ignored
        reg_wr(2'd0, 8'h01);
        reg_wr(2'd0, 8'h02);
        chk(ctl_status == 8'h81, "R10 status unchanged while busy", ctl_status, 8'h81);
        for (int w = 0; w < 200 && ctl_status[7]; w++) @(negedge clk);
        chk(ctl_status == 8'h00, "R2 idle after done", ctl_status, 8'h00);
        chk(cpu_stall == 1'b0, "R4 stall released", cpu_stall, 0);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R10 no extra request", exp_q.size(), 0);

        // R6 locked page 5 (0x0A)
        reg_wr(2'd1, 8'h0A);
        reg_wr(2'd0, 8'h01);
        chk(ctl_status == 8'h20, "R6 abort set, not busy", ctl_status, 8'h20);
        repeat (LAT + 5) @(negedge clk);
        chk(ctl_status == 8'h20 && !cpu_stall, "R6 still refused", ctl_status, 8'h20);

        // R11 bytes while idle ignored
        t0 = trig_cnt;
        reg_wr(2'd2, 8'hEE); reg_wr(2'd2, 8'hEE); reg_wr(2'd2, 8'hEE);
        repeat (3) @(negedge clk);
        chk(trig_cnt == t0, "R11 no trigger when idle", trig_cnt, t0);
        chk(ctl_status == 8'h20, "R11 status untouched", ctl_status, 8'h20);

        // R7/R8 write two words at page 3 (0x06 -> 1536)
        reg_wr(2'd1, 8'h06);
        push(1'b1, 1536, 32'h44332211);
        push(1'b1, 1537, 32'h88776655);
        t0 = trig_cnt;
        reg_wr(2'd0, 8'h02);
        chk(ctl_status == 8'h82, "R7 write status, R6 abort cleared", ctl_status, 8'h82);
        @(negedge clk);
        chk(trig_cnt == t0 + 1, "R8 trigger at start", trig_cnt, t0 + 1);
        consumed = t0;
        for (int i = 0; i < 8; i++) begin
            for (int w = 0; w < 500 && trig_cnt <= consumed; w++) @(negedge clk);
            consumed++;
            reg_wr(2'd2, 8'((i + 1) * 8'h11));
        end
        for (int w = 0; w < 500 && trig_cnt <= consumed; w++) @(negedge clk);
        chk(trig_cnt == t0 + 9, "R8 trigger count for two words", trig_cnt, t0 + 9);
        chk(exp_q.size() == 0, "R7 both words programmed", exp_q.size(), 0);

        // R9 timeout
        repeat (TMO - 8) @(negedge clk);
        chk(ctl_status == 8'h82, "R9 still writing before timeout", ctl_status, 8'h82);
        repeat (12) @(negedge clk);
        chk(ctl_status == 8'h00, "R9 write cleared by timeout", ctl_status, 8'h00);
        chk(cpu_stall == 1'b0, "R9 stall released", cpu_stall, 0);

        // R3 1 KB mode: 0x85 -> page 5 -> word 1280
        k_wr(2'd1, 8'h85);
        k_wr(2'd0, 8'h01);
        for (int w = 0; w < 50 && !k_seen; w++) @(negedge clk);
        chk(k_seen && k_addr_seen == 1280, "R3 1 KB erase address", k_addr_seen, 1280);
        for (int w = 0; w < 50 && k_status[7]; w++) @(negedge clk);
        chk(k_status == 8'h00, "R3 1 KB erase completes", k_status, 8'h00);

        report();
    end
endmodule